// File: doc/BRIEF.md
# Tri-State Phase Frequency Detector

This block compares two divided clock streams, a reference divider output and a feedback divider output, and turns the timing difference between their rising edges into two pump-request levels, `up_o` and `dn_o`. All of it runs in one fast system clock domain. Both divider outputs reach it as synchronous signals, which may be single-cycle strobes or held levels. Only their rising transitions matter. The width of each request tracks the phase and frequency error, so a downstream charge pump model can integrate `up_o` minus `dn_o`.

Each side has a request flag. A rising edge on its input sets the flag. Once both flags are high, a clear timer lets them overlap for exactly `ANTIBACKLASH_CYCLES` system clocks and then drops both on the same edge. This guaranteed overlap keeps a pulse on both outputs even at zero phase error, which removes the dead zone around lock. An edge that arrives while the overlap is running is held back and applied right after the joint clear, so it is not lost. The inputs are plain control pins with no handshake.

Top module: `tri_state_pfd`

## Requirements
- R1: While `rst` is high at a clock edge, `up_o` and `dn_o` are low after that edge, and any request in progress is dropped.
- R2: A rising transition sampled on `ref_div_i` (high at an edge after being low at the previous edge) makes `up_o` high after that same edge. A rising transition on `fb_div_i` does the same for `dn_o`.
- R3: Once `up_o` and `dn_o` are both high, they stay high together for exactly `ANTIBACKLASH_CYCLES` clock cycles and then go low on the same edge.
- R4: When the reference edge leads the feedback edge by D cycles, `up_o` is high for D + `ANTIBACKLASH_CYCLES` cycles and `dn_o` for `ANTIBACKLASH_CYCLES` cycles. When the feedback edge leads, the roles are swapped. The difference between the two pulse lengths is always D.
- R5: When both edges arrive on the same cycle, each output produces one pulse exactly `ANTIBACKLASH_CYCLES` cycles wide (no dead zone).
- R6: A further rising edge on a side whose request is already high, before any overlap, has no effect: that output stays one continuous pulse and ends only with the joint clear.
- R7: A rising edge that arrives while both requests are high is kept. This includes an edge on the clearing edge itself. Its request goes high again one clock after the joint clear, leaving a one-cycle low gap.
- R8: A held-high level input gives the same result as a one-cycle strobe with the same rising time. A level that stays high never causes a second request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_div_i | input | 1 | Reference divider output, strobe or level |
| fb_div_i | input | 1 | Feedback divider output, strobe or level |
| up_o | output | 1 | Registered pump-up request |
| dn_o | output | 1 | Registered pump-down request |

## Verification
The detector is driven with edge pairs that are coincident, reference-leading by one and by five cycles, and feedback-leading by seven cycles. Together these separate a correct pulse-length difference from an off-by-one in the clear timer and from a swapped up/down mapping. Held-level inputs are set against strobes to show that only rising transitions count. A doubled reference edge before any feedback edge shows that extra edges on a side whose request is already high are ignored. Edges placed inside the overlap window, and on its clearing edge, show that the pending edge is kept and comes out as a second pulse after a one-cycle gap. A reset applied mid-request shows that reset drops the request at once.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;
  localparam int NUM_SIDES = 2;
  localparam int SIDE_REF  = 0;
  localparam int SIDE_FB   = 1;

  function automatic int count_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/pfd_edge_detect.sv
`timescale 1ns/1ps
module pfd_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/pfd_req_latch.sv
`timescale 1ns/1ps
module pfd_req_latch (
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  input  logic overlap_i,
  input  logic clear_i,
  output logic req_o
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o  <= 1'b0;
      pend_q <= 1'b0;
    end else if (clear_i) begin
      req_o  <= 1'b0;
      pend_q <= pend_q | rise_i;
    end else if (pend_q) begin
      req_o  <= 1'b1;
      pend_q <= 1'b0;
    end else if (rise_i) begin
      if (overlap_i) pend_q <= 1'b1;
      else           req_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/pfd_clear_timer.sv
`timescale 1ns/1ps
module pfd_clear_timer #(
  parameter int ANTIBACKLASH_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic overlap_i,
  output logic clear_o
);
  import pfd_pkg::*;
  localparam int CNT_W = count_width(ANTIBACKLASH_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ANTIBACKLASH_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign clear_o = overlap_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (!overlap_i) cnt_q <= '0;
    else if (clear_o)   cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tri_state_pfd.sv
`timescale 1ns/1ps
module tri_state_pfd #(
  parameter int ANTIBACKLASH_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_div_i,
  input  logic fb_div_i,
  output logic up_o,
  output logic dn_o
);
  import pfd_pkg::*;

  logic [NUM_SIDES-1:0] side_in;
  logic [NUM_SIDES-1:0] side_rise;
  logic [NUM_SIDES-1:0] side_req;
  logic                 overlap;
  logic                 clear;

  assign side_in[SIDE_REF] = ref_div_i;
  assign side_in[SIDE_FB]  = fb_div_i;
  assign overlap = &side_req;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    pfd_edge_detect edge_i (
      .clk    (clk),
      .rst    (rst),
      .sig_i  (side_in[s]),
      .rise_o (side_rise[s])
    );
    pfd_req_latch req_i (
      .clk       (clk),
      .rst       (rst),
      .rise_i    (side_rise[s]),
      .overlap_i (overlap),
      .clear_i   (clear),
      .req_o     (side_req[s])
    );
  end

  pfd_clear_timer #(.ANTIBACKLASH_CYCLES(ANTIBACKLASH_CYCLES)) timer_i (
    .clk       (clk),
    .rst       (rst),
    .overlap_i (overlap),
    .clear_o   (clear)
  );

  assign up_o = side_req[SIDE_REF];
  assign dn_o = side_req[SIDE_FB];
endmodule

// File: rtl/tri_state_pfd_chk.sv
`timescale 1ns/1ps
module tri_state_pfd_chk #(
  parameter int ANTIBACKLASH_CYCLES = 3
) (
  input logic clk,
  input logic rst,
  input logic ref_div_i,
  input logic fb_div_i,
  input logic up_o,
  input logic dn_o
);
  logic        ref_prev, fb_prev;
  logic [31:0] both_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_prev <= 1'b0;
      fb_prev  <= 1'b0;
      both_run <= '0;
    end else begin
      ref_prev <= ref_div_i;
      fb_prev  <= fb_div_i;
      both_run <= (up_o && dn_o) ? both_run + 1 : '0;
    end
  end

  AST_RESET_DROPS: assert property (@(posedge clk) rst |=> (!up_o && !dn_o)); // R1
  AST_REF_SETS_UP: assert property (@(posedge clk) disable iff (rst)
    (ref_div_i && !ref_prev && !(up_o && dn_o)) |=> up_o); // R2
  AST_FB_SETS_DN: assert property (@(posedge clk) disable iff (rst)
    (fb_div_i && !fb_prev && !(up_o && dn_o)) |=> dn_o); // R2
  AST_OVERLAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (up_o && dn_o && (both_run < 32'(ANTIBACKLASH_CYCLES - 1))) |=> (up_o && dn_o)); // R3
  AST_OVERLAP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (up_o && dn_o && (both_run == 32'(ANTIBACKLASH_CYCLES - 1))) |=> (!up_o && !dn_o)); // R3
  AST_JOINT_FALL: assert property (@(posedge clk) disable iff (rst)
    (up_o && dn_o) |=> ((up_o && dn_o) || (!up_o && !dn_o))); // R3
  AST_UP_HELD_ALONE: assert property (@(posedge clk) disable iff (rst)
    (up_o && !dn_o) |=> up_o); // R6
  AST_DN_HELD_ALONE: assert property (@(posedge clk) disable iff (rst)
    (dn_o && !up_o) |=> dn_o); // R6
endmodule

bind tri_state_pfd tri_state_pfd_chk #(.ANTIBACKLASH_CYCLES(ANTIBACKLASH_CYCLES)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .ref_div_i (ref_div_i),
  .fb_div_i  (fb_div_i),
  .up_o      (up_o),
  .dn_o      (dn_o)
);

// File: tb/tri_state_pfd_tb_top.sv
`timescale 1ns/1ps
module tri_state_pfd_tb_top;
  localparam int AB   = 3;
  localparam int NONE = 99;
  localparam int WIN  = 40;
  localparam int NV   = 8;

  typedef struct packed {
    int r0; int r1; int f0; int f1; int w;
    int up; int dn; int upr; int dnr; int req;
  } vec_t;

  // fields: ref strobes, fb strobes, width, expected up/dn cycles, expected pulse counts, requirement
  localparam vec_t VEC [NV] = '{
    '{0, NONE, 0, NONE, 1,  AB,    AB,    1, 1, 5}, // R5 coincident
    '{0, NONE, 5, NONE, 1,  5+AB,  AB,    1, 1, 4}, // R4 ref leads by 5
    '{7, NONE, 0, NONE, 1,  AB,    7+AB,  1, 1, 4}, // R4 fb leads by 7
    '{0, NONE, 1, NONE, 1,  1+AB,  AB,    1, 1, 4}, // R4 ref leads by 1
    '{0, NONE, 4, NONE, 20, 4+AB,  AB,    1, 1, 8}, // R8 held levels
    '{0, 3,    10, NONE, 1, 10+AB, AB,    1, 1, 6}, // R6 doubled ref edge
    '{0, 2,    0, 6,    1,  AB+5,  2*AB,  2, 2, 7}, // R7 edge inside overlap
    '{0, 3,    0, 6,    1,  AB+5,  2*AB,  2, 2, 7}  // R7 edge on clearing edge
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_div_i = 1'b0;
  logic fb_div_i  = 1'b0;
  logic up_o, dn_o;
  int   checks = 0;
  int   errors = 0;

  always #4 clk = ~clk;

  tri_state_pfd #(.ANTIBACKLASH_CYCLES(AB)) dut_i (
    .clk(clk), .rst(rst), .ref_div_i(ref_div_i), .fb_div_i(fb_div_i),
    .up_o(up_o), .dn_o(dn_o)
  );

  task automatic check(input int req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic run_vec(input vec_t v);
    int up_n = 0, dn_n = 0, up_r = 0, dn_r = 0;
    logic up_p = 1'b0, dn_p = 1'b0;
    for (int t = 0; t < WIN; t++) begin
      @(negedge clk);
      if (up_o) up_n++;
      if (dn_o) dn_n++;
      if (up_o && !up_p) up_r++;
      if (dn_o && !dn_p) dn_r++;
      up_p = up_o;
      dn_p = dn_o;
      ref_div_i = (t >= v.r0 && t < v.r0 + v.w) || (t >= v.r1 && t < v.r1 + v.w);
      fb_div_i  = (t >= v.f0 && t < v.f0 + v.w) || (t >= v.f1 && t < v.f1 + v.w);
    end
    check(v.req, "up cycles", up_n, v.up);
    check(v.req, "dn cycles", dn_n, v.dn);
    check(v.req, "up pulses", up_r, v.upr);
    check(v.req, "dn pulses", dn_r, v.dnr);
    check(4, "up minus dn cycles", up_n - dn_n, v.up - v.dn); // R4
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(1, "up after reset", int'(up_o), 0); // R1
    check(1, "dn after reset", int'(dn_o), 0); // R1

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R2: single ref edge raises up one edge later
    @(negedge clk);
    ref_div_i = 1'b1;
    @(negedge clk);
    check(2, "up after ref edge", int'(up_o), 1);
    check(2, "dn idle", int'(dn_o), 0);
    // R1: reset mid-request drops it
    ref_div_i = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(1, "up dropped by reset", int'(up_o), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(1, "up stays low after reset", int'(up_o), 0);
    check(1, "dn stays low after reset", int'(dn_o), 0);

    // R7: cycle-exact gap after joint clear
    @(negedge clk);
    ref_div_i = 1'b1; fb_div_i = 1'b1;
    @(negedge clk);
    ref_div_i = 1'b0; fb_div_i = 1'b0;
    @(negedge clk);
    ref_div_i = 1'b1;
    @(negedge clk);
    ref_div_i = 1'b0;
    @(negedge clk);
    check(7, "up in gap", int'(up_o), 0);
    check(7, "dn in gap", int'(dn_o), 0);
    @(negedge clk);
    check(7, "up re-raised", int'(up_o), 1);
    check(7, "dn after gap", int'(dn_o), 0);
    fb_div_i = 1'b1;
    @(negedge clk);
    fb_div_i = 1'b0;
    repeat (AB + 2) @(negedge clk);
    check(3, "up cleared", int'(up_o), 0);
    check(3, "dn cleared", int'(dn_o), 0);

    finish_run();
  end
endmodule